// File: doc/BRIEF.md
# Raster pattern color register expander

This block holds six 32-bit pattern color words for the pattern stage of a 2D blitter. A bus port writes and reads them by word index. In monochrome pattern mode each write is expanded to fill the word according to the current color depth. In color pattern mode each write is stored unchanged. A raster mode input selects the color depth and the pattern mode. A busy flag from the blit engine stops writes to the words that the running blit reads without a pipeline stage.

The raster path asks for a pattern pixel with a line number, a pixel index and a monochrome pattern bit, and gets back a color with no clock delay. In solid mode the color is word 0. In monochrome mode the pattern bit picks word 0 or word 1. In color mode the words form a fixed window of the 8x8 pattern, and the block pulls the pixel out of that window. A pixel outside the window returns zero and is flagged as not held.

Top module: `patcol_bank`

## Requirements
- R1: After reset all six words read 00000000h and `prot_err` is 0.
- R2: With `pmode`=1 (monochrome) and `depth`=0 (8 bpp), an accepted write stores the low byte of `wr_data` in all four bytes of the word.
- R3: With `pmode`=1 and `depth`=1 (16 bpp), an accepted write stores the low 16 bits of `wr_data` in both halves. With `pmode`=1 and `depth`=2 or 3 (32 bpp), the data is stored as written.
- R4: With `pmode`=0, 2 or 3, an accepted write stores `wr_data` exactly, whatever the depth.
- R5: `rd_data` shows the stored word selected by `rd_idx` (0..5) in the same cycle. Indices 6 and 7 read zero, and writes to them change nothing.
- R6: With `pmode`=0 (solid) or 3, `pix_color` equals word 0 and `pix_held` is 1 for every request.
- R7: With `pmode`=1, `pix_color` is word 0 when `req_mono` is 0 and word 1 when it is 1, and `pix_held` is 1.
- R8: With `pmode`=2 (color), the word holding a pixel is found as follows. At 8 bpp, lines 1..3 are held and the word is 2*(line-1)+pix/4, byte lane pix%4. At 16 bpp, line 0 pixels 4..7 sit in word (pix-4)/2 and line 1 in word 2+pix/2, halfword pix%2. At 32 bpp, line 0 pixels 2..7 sit in word pix-2. The lowest-numbered pixel takes the least significant bits, and the result is zero-extended.
- R9: In color mode a pixel outside the held window gives `pix_color`=0 and `pix_held`=0.
- R10: While `busy` is 1, a write to words 2..5 is dropped and sets `prot_err`, which then stays 1 until reset. Writes to words 0..1 are accepted while busy.
- R11: Replication uses `pmode` and `depth` at the time of the write. A later mode change does not change stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Word index to write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Word index to read |
| rd_data | output | 32 | Read data |
| depth | input | 2 | Color depth: 0=8, 1=16, 2/3=32 bpp |
| pmode | input | 2 | Pattern mode: 0 solid, 1 monochrome, 2 color, 3 solid |
| busy | input | 1 | Blit in progress |
| req_line | input | 3 | Requested pattern line |
| req_pix | input | 3 | Requested pixel in the line |
| req_mono | input | 1 | Monochrome pattern bit |
| pix_color | output | 32 | Pattern pixel color |
| pix_held | output | 1 | Pixel lies in the held window |
| prot_err | output | 1 | Sticky dropped-write flag |

## Verification
The bench sweeps every line and pixel at all three depths in color mode. A window misplaced by one word would return a neighbour's pixels, and a wrong lane order would reverse the pixels inside a word. It writes to words 1 and 2 while busy, because that is where the protected range starts. An off-by-one guard would either corrupt the blit or lock out an expansion color. It also writes in one mode and reads in another to catch replication that is applied at read time. It writes to index 6 to catch an aliased write that lands in word 0 or 2.

// File: rtl/patcol_pkg.sv
package patcol_pkg;
  localparam int DW       = 32;
  localparam int NREG     = 6;
  localparam int IDXW     = 3;
  localparam int LINEW    = 3;
  localparam int PIXW     = 3;
  localparam int PROT_LO  = 2;
  localparam int WIN_BASE = 8;
  localparam int LANES    = DW / 8;
  localparam int LANEW    = $clog2(LANES);

  typedef enum logic [1:0] {DEP8 = 2'd0, DEP16 = 2'd1, DEP32 = 2'd2, DEP32X = 2'd3} depth_e;
  typedef enum logic [1:0] {PM_SOLID = 2'd0, PM_MONO = 2'd1, PM_COLOR = 2'd2, PM_RSVD = 2'd3} pmode_e;

  function automatic logic [DW-1:0] expand_word(input logic [DW-1:0] d,
                                                input pmode_e pm, input depth_e dp);
    if (pm != PM_MONO) return d;
    case (dp)
      DEP8:    return {(DW/8){d[7:0]}};
      DEP16:   return {(DW/16){d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_pick(input logic [DW-1:0] w,
                                              input logic [LANEW-1:0] lane, input depth_e dp);
    logic [DW-1:0] s;
    s = w >> {lane, 3'b000};
    case (dp)
      DEP8:    return {{(DW-8){1'b0}}, s[7:0]};
      DEP16:   return {{(DW-16){1'b0}}, s[15:0]};
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/patcol_wrctl.sv
module patcol_wrctl
  import patcol_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  pmode_e          pm,
  input  depth_e          dp,
  input  logic            busy,
  output logic [NREG-1:0] load,
  output logic [DW-1:0]   wdata,
  output logic            wr_block,
  output logic            err
);
  logic idx_ok, guarded, wr_take;

  always_comb begin
    idx_ok   = wr_idx < IDXW'(NREG);
    guarded  = wr_idx >= IDXW'(PROT_LO);
    wr_block = wr_en && idx_ok && guarded && busy;
    wr_take  = wr_en && idx_ok && !wr_block;
    load     = '0;
    if (wr_take) load[wr_idx] = 1'b1;
    wdata    = expand_word(wr_data, pm, dp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err <= 1'b0;
    else if (wr_block) err <= 1'b1;
  end
endmodule

// File: rtl/patcol_regs.sv
module patcol_regs
  import patcol_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] load,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   q [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[g] <= '0;
      else if (load[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/patcol_select.sv
module patcol_select
  import patcol_pkg::*;
(
  input  pmode_e           pm,
  input  depth_e           dp,
  input  logic [LINEW-1:0] line,
  input  logic [PIXW-1:0]  pix,
  input  logic             mono_bit,
  input  logic [DW-1:0]    bank [NREG],
  output logic [DW-1:0]    color,
  output logic             held
);
  localparam int POSW  = LINEW + PIXW;
  localparam int BOFFW = POSW + LANEW;
  localparam int RIDXW = $clog2(NREG);

  logic [POSW-1:0]  pos;
  logic [BOFFW-1:0] boff, rel;
  logic             in_win;
  logic [RIDXW-1:0] ridx;
  logic [LANEW-1:0] lane;
  logic [DW-1:0]    word;
  wire unused_rel_hi = ^rel[BOFFW-1:LANEW+RIDXW];

  always_comb begin
    pos = {line, pix};
    case (dp)
      DEP8:    boff = {2'b00, pos};
      DEP16:   boff = {1'b0, pos, 1'b0};
      default: boff = {pos, 2'b00};
    endcase
    in_win = (boff >= BOFFW'(WIN_BASE)) && (boff < BOFFW'(WIN_BASE + NREG * LANES));
    rel    = boff - BOFFW'(WIN_BASE);
    ridx   = rel[LANEW +: RIDXW];
    lane   = rel[LANEW-1:0];
    word   = in_win ? bank[ridx] : '0;
    case (pm)
      PM_MONO: begin
        color = mono_bit ? bank[1] : bank[0];
        held  = 1'b1;
      end
      PM_COLOR: begin
        color = in_win ? lane_pick(word, lane, dp) : '0;
        held  = in_win;
      end
      default: begin
        color = bank[0];
        held  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/patcol_bank.sv
module patcol_bank
  import patcol_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic [1:0]  depth,
  input  logic [1:0]  pmode,
  input  logic        busy,
  input  logic [2:0]  req_line,
  input  logic [2:0]  req_pix,
  input  logic        req_mono,
  output logic [31:0] pix_color,
  output logic        pix_held,
  output logic        prot_err
);
  pmode_e             pm;
  depth_e             dp;
  logic [NREG-1:0]    wr_load;
  logic [DW-1:0]      wr_word;
  logic               wr_block;
  logic [DW-1:0]      bank [NREG];
  logic [NREG*DW-1:0] bank_flat;

  assign pm = pmode_e'(pmode);
  assign dp = depth_e'(depth);

  patcol_wrctl u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pm(pm), .dp(dp), .busy(busy), .load(wr_load), .wdata(wr_word),
    .wr_block(wr_block), .err(prot_err)
  );

  patcol_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .wdata(wr_word), .q(bank)
  );

  patcol_select u_sel (
    .pm(pm), .dp(dp), .line(req_line), .pix(req_pix), .mono_bit(req_mono),
    .bank(bank), .color(pix_color), .held(pix_held)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bank_flat[g*DW +: DW] = bank[g];
  end

  assign rd_data = (rd_idx < 3'(NREG)) ? bank[rd_idx] : '0;
endmodule

// File: rtl/patcol_bank_chk.sv
module patcol_bank_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_idx,
  input logic [31:0]  wr_data,
  input logic [1:0]   pmode,
  input logic [1:0]   depth,
  input logic         req_mono,
  input logic [31:0]  pix_color,
  input logic         pix_held,
  input logic         prot_err,
  input logic         wr_block,
  input logic [5:0]   wr_load,
  input logic [191:0] bank_flat
);
  a_r10_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> $stable(bank_flat));
  a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> prot_err);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);
  a_r10_low_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 3'd2) |-> $onehot0(wr_load) && wr_load != 6'd0);
  a_r5_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > 3'd5) |=> $stable(bank_flat));
  a_r2_mono8_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load != 6'd0 && pmode == 2'd1 && depth == 2'd0) |=>
      bank_flat[$past(wr_idx)*32 +: 32] == {4{$past(wr_data[7:0])}});
  a_r4_color_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load != 6'd0 && pmode == 2'd2) |=>
      bank_flat[$past(wr_idx)*32 +: 32] == $past(wr_data));
  a_r6_solid: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode == 2'd0) |-> (pix_color == bank_flat[31:0] && pix_held));
  a_r7_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode == 2'd1) |-> (pix_color == (req_mono ? bank_flat[63:32] : bank_flat[31:0])));
  a_r9_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_held |-> pix_color == 32'd0);
endmodule

bind patcol_bank patcol_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .pmode(pmode), .depth(depth), .req_mono(req_mono), .pix_color(pix_color),
  .pix_held(pix_held), .prot_err(prot_err), .wr_block(wr_block),
  .wr_load(wr_load), .bank_flat(bank_flat)
);

// File: tb/sim_patcol_bank.sv
`timescale 1ns/1ps
module sim_patcol_bank;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, busy = 0, req_mono = 0;
  logic [2:0]  wr_idx = 0, rd_idx = 0, req_line = 0, req_pix = 0;
  logic [31:0] wr_data = 0;
  logic [1:0]  depth = 0, pmode = 0;
  logic [31:0] rd_data, pix_color;
  logic        pix_held, prot_err;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m [6];
  bit m_err = 0;

  always #2.5 clk = ~clk;

  patcol_bank u0 (.*);

  function automatic logic [31:0] b_store(logic [31:0] d, logic [1:0] pm, logic [1:0] dp);
    logic [31:0] r;
    r = d;
    if (pm == 2'd1 && dp == 2'd0) for (int k = 0; k < 4; k++) r[8*k +: 8] = d[7:0];
    if (pm == 2'd1 && dp == 2'd1) r[31:16] = d[15:0];
    return r;
  endfunction

  function automatic logic [32:0] b_pixel(int line, int pix, bit mb, logic [1:0] pm, logic [1:0] dp);
    int w; int ln;
    if (pm == 2'd1) return {1'b1, mb ? m[1] : m[0]};
    if (pm != 2'd2) return {1'b1, m[0]};
    w = -1; ln = 0;
    if (dp == 2'd0) begin
      if (line >= 1 && line <= 3) begin w = (line - 1) * 2 + pix / 4; ln = pix % 4; end
      if (w >= 0) return {1'b1, 24'd0, m[w][8*ln +: 8]};
    end else if (dp == 2'd1) begin
      if (line == 0 && pix >= 4) w = (pix - 4) / 2;
      if (line == 1) w = 2 + pix / 2;
      ln = pix % 2;
      if (w >= 0) return {1'b1, 16'd0, m[w][16*ln +: 16]};
    end else begin
      if (line == 0 && pix >= 2) w = pix - 2;
      if (w >= 0) return {1'b1, m[w]};
    end
    return 33'd0;
  endfunction

  task automatic chk(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_data = d;
    if (idx < 6) begin
      if (busy && idx >= 2) m_err = 1;
      else m[idx] = b_store(d, pmode, depth);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdchk(int idx, string tag);
    logic [31:0] e;
    rd_idx = 3'(idx); #1;
    e = (idx < 6) ? m[idx] : 32'd0;
    chk(rd_data === e, tag, {1'b0, rd_data}, {1'b0, e});
  endtask

  task automatic pxchk(int line, int pix, bit mb, string tag);
    logic [32:0] e;
    req_line = 3'(line); req_pix = 3'(pix); req_mono = mb; #1;
    e = b_pixel(line, pix, mb, pmode, depth);
    chk({pix_held, pix_color} === e, tag, {pix_held, pix_color}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 6; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 6; i++) rdchk(i, "R1 reset word");
    chk(prot_err === 1'b0, "R1 reset err", {32'd0, prot_err}, 33'd0);
    // R2 / R3 / R4 replication
    pmode = 1; depth = 0; wr(2, 32'h123456AB); rdchk(2, "R2 mono8");
    depth = 1; wr(3, 32'hDEADBEEF); rdchk(3, "R3 mono16");
    depth = 2; wr(4, 32'hCAFEF00D); rdchk(4, "R3 mono32");
    depth = 3; wr(1, 32'h0BADC0DE); rdchk(1, "R3 mono32 alt");
    pmode = 2; depth = 0; wr(5, 32'h89ABCDEF); rdchk(5, "R4 color8 exact");
    pmode = 0; depth = 1; wr(0, 32'h55AA1234); rdchk(0, "R4 solid exact");
    // R11 mode change after write
    pmode = 1; depth = 0; rdchk(5, "R11 mode change keeps word");
    // R5 high index
    wr(6, 32'hFFFFFFFF); wr(7, 32'h01010101);
    for (int i = 0; i < 8; i++) rdchk(i, "R5 read after high write");
    // R6 solid and R7 mono
    pmode = 0; pxchk(5, 3, 1, "R6 solid"); pmode = 3; pxchk(0, 0, 0, "R6 mode3");
    pmode = 1; pxchk(2, 7, 0, "R7 mono0"); pxchk(2, 7, 1, "R7 mono1");
    // R8 / R9 full color sweep
    pmode = 2; depth = 2;
    for (int i = 0; i < 6; i++) wr(i, 32'h10203040 + 32'(i) * 32'h01010101);
    for (int dp = 0; dp < 3; dp++) begin
      depth = 2'(dp);
      for (int ln = 0; ln < 8; ln++)
        for (int px = 0; px < 8; px++) pxchk(ln, px, 0, "R8 R9 color window");
    end
    // R10 busy protection
    busy = 1; pmode = 1; depth = 0;
    wr(2, 32'h77); rdchk(2, "R10 busy drop word2");
    chk(prot_err === 1'b1, "R10 err set", {32'd0, prot_err}, 33'd1);
    wr(1, 32'h66); rdchk(1, "R10 busy accept word1");
    busy = 0; wr(0, 32'h12);
    chk(prot_err === 1'b1, "R10 err sticky", {32'd0, prot_err}, 33'd1);
    // random phase
    for (int it = 0; it < 400; it++) begin
      pmode = 2'($urandom_range(0, 3)); depth = 2'($urandom_range(0, 3));
      busy = ($urandom_range(0, 3) == 0);
      wr(int'($urandom_range(0, 7)), $urandom);
      rdchk(int'($urandom_range(0, 7)), "R5 R2 R3 R4 R10 random read");
      pmode = 2'($urandom_range(0, 3)); depth = 2'($urandom_range(0, 3));
      pxchk(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 1'($urandom), "R6 R7 R8 R9 R11 random pixel");
      chk(prot_err === m_err, "R10 random err", {32'd0, prot_err}, {32'd0, m_err});
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule